// File: doc/BRIEF.md
# Support Change Detector Controller

This block decides, frame by frame, whether the signal support currently used for reconstruction is still valid. Each frame is a run of twelve complex sample/control pairs. The block multiplies every sample by its control entry and adds the twelve complex products into one complex sum. It then squares the real and imaginary parts of that sum and adds them to form an energy figure. When the energy is above a programmable threshold, the frame counts as a failure.

A failure requests a new support calculation from the support-finding stage. An escalation state machine counts consecutive failures. When the count reaches a programmable limit in normal mode, the block moves to iteration mode. When the count reaches the same limit again while in iteration mode, the block raises a sticky error. An upstream controller acknowledges each request and clears the error when it recovers.

Top module: `support_change_monitor`

## Requirements
- R1: Each accepted pair contributes the complex product real = sr*cr - si*ci and imag = sr*ci + si*cr. The samples and control entries are 18-bit signed two's-complement raw integers (16 fractional bits), and the energy is in raw units squared.
- R2: A frame ends when exactly FRAME_LEN (12) pairs with in_valid high have been accepted. Cycles with in_valid low add nothing. The pair that follows a completed frame starts a new frame.
- R3: The energy is re*re + im*im of the frame sum, computed exactly with no overflow or truncation. A frame fails only if the energy is strictly greater than threshold.
- R4: frame_start discards any partial sum. A pair presented in the same cycle as frame_start is the first pair of the new frame.
- R5: recalc_req is a one-cycle pulse. It is high in the second cycle after the clock edge that accepts the frame's last pair.
- R6: Consecutive failures in normal mode that reach fail_limit set iter_mode in the cycle of that frame's decision and clear the failure count. A fail_limit of 0 behaves as 1.
- R7: A passing frame clears the consecutive-failure count and leaves the mode unchanged.
- R8: After a request, further failures raise no new pulse until recalc_ack is seen. An acknowledge in the same cycle as a decision takes effect first.
- R9: Consecutive failures in iteration mode that reach fail_limit set error. error stays high until err_clear, and is only ever high in iteration mode.
- R10: err_clear clears error, returns to normal mode and clears the failure count. It takes priority over a frame decision in the same cycle.
- R11: After reset, recalc_req, iter_mode and error are low, the mode is normal and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Discard partial sum and begin a new frame |
| in_valid | input | 1 | Sample/control pair is presented this cycle |
| samp_re | input | 18 | Sample real part, signed |
| samp_im | input | 18 | Sample imaginary part, signed |
| ctl_re | input | 18 | Control entry real part, signed |
| ctl_im | input | 18 | Control entry imaginary part, signed |
| threshold | input | 82 | Unsigned energy threshold |
| fail_limit | input | 8 | Consecutive failures before escalation |
| recalc_ack | input | 1 | Acknowledge of a recalculation request |
| err_clear | input | 1 | Clear error and return to normal mode |
| recalc_req | output | 1 | One-cycle request for a new support |
| iter_mode | output | 1 | Level, high in iteration mode |
| error | output | 1 | Sticky error level |

## Verification
A wrong frame count or a stale partial sum moves the decision cycle, or makes a quiet frame fail. This is visible on recalc_req within three cycles of the twelfth pair. A truncated or overflowed energy flips the pass/fail result at a threshold set one unit below or at the exact expected energy. Such thresholds are used for both small and full-scale operands. A wrong failure count or pending flag shows up as iter_mode or error changing one frame early or late, or as a missing or extra request pulse. The bench reads these at the decision cycle of each frame.

// File: rtl/scm_pkg.sv
// Shared types and width helpers for the support change monitor.
// Assumes operands are signed two's-complement fixed point.
package scm_pkg;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_ITER   = 1'b1
    } scm_mode_e;

    // Width of a complex sum of n products of dw-bit signed operands
    function automatic int acc_width(input int dw, input int n);
        return 2 * dw + 1 + $clog2(n);
    endfunction

endpackage

// File: rtl/scm_cmac.sv
// Complex multiply-accumulate over one frame of FRAME_LEN valid pairs.
// Assumes in_valid qualifies every pair; frame_start restarts the frame.
// The sum is held on sum_re/sum_im while done pulses for one cycle.
module scm_cmac #(
    parameter int DW        = 18,
    parameter int FRAME_LEN = 12,
    parameter int ACC_W     = 41
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    s_re,
    input  logic signed [DW-1:0]    s_im,
    input  logic signed [DW-1:0]    c_re,
    input  logic signed [DW-1:0]    c_im,
    output logic                    done,
    output logic signed [ACC_W-1:0] sum_re,
    output logic signed [ACC_W-1:0] sum_im
);
    localparam int PW = 2 * DW + 1;
    localparam int FW = $clog2(FRAME_LEN + 1);

    logic signed [PW-1:0]    sr_x, si_x, cr_x, ci_x;
    logic signed [PW-1:0]    prod_re, prod_im;
    logic signed [ACC_W-1:0] base_re, base_im;
    logic [FW-1:0]           cnt, cnt_base, cnt_next;
    logic                    first;

    // Sign-extended complex product of the current pair
    always_comb begin
        sr_x    = PW'(s_re);
        si_x    = PW'(s_im);
        cr_x    = PW'(c_re);
        ci_x    = PW'(c_im);
        prod_re = sr_x * cr_x - si_x * ci_x;
        prod_im = sr_x * ci_x + si_x * cr_x;
    end

    // Select a fresh or running base for the accumulation
    always_comb begin
        first    = frame_start || (cnt == '0);
        base_re  = first ? '0 : sum_re;
        base_im  = first ? '0 : sum_im;
        cnt_base = first ? '0 : cnt;
        cnt_next = cnt_base + 1'b1;
    end

    // Accumulate pairs and flag the end of each frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sum_re <= '0;
            sum_im <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (in_valid) begin
                sum_re <= base_re + ACC_W'(prod_re);
                sum_im <= base_im + ACC_W'(prod_im);
                if (cnt_next == FW'(FRAME_LEN)) begin
                    cnt  <= '0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt_next;
                end
            end else if (frame_start) begin
                cnt    <= '0;
                sum_re <= '0;
                sum_im <= '0;
            end
        end
    end

endmodule

// File: rtl/scm_energy.sv
// Energy of a complex sum and comparison against an unsigned threshold.
// Assumes EW = 2*ACC_W, which holds the largest energy exactly.
// One register stage: chk_valid follows done by one cycle.
module scm_energy #(
    parameter int ACC_W = 41,
    parameter int EW    = 82
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    done,
    input  logic signed [ACC_W-1:0] sum_re,
    input  logic signed [ACC_W-1:0] sum_im,
    input  logic [EW-1:0]           threshold,
    output logic                    chk_valid,
    output logic                    fail
);
    logic signed [EW-1:0] re_x, im_x, sq_re, sq_im;
    logic [EW-1:0]        energy;

    // Exact squared magnitude of the frame sum
    always_comb begin
        re_x   = EW'(sum_re);
        im_x   = EW'(sum_im);
        sq_re  = re_x * re_x;
        sq_im  = im_x * im_x;
        energy = $unsigned(sq_re) + $unsigned(sq_im);
    end

    // Register the pass/fail verdict of each completed frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            fail      <= 1'b0;
        end else begin
            chk_valid <= done;
            if (done) begin
                fail <= energy > threshold;
            end
        end
    end

endmodule

// File: rtl/scm_escalate.sv
// Two-level escalation state machine driven by per-frame verdicts.
// Assumes chk_valid pulses once per frame with fail valid alongside it.
// Normal mode escalates to iteration mode; iteration mode raises error.
module scm_escalate
    import scm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_valid,
    input  logic             fail,
    input  logic [CNT_W-1:0] fail_limit,
    input  logic             recalc_ack,
    input  logic             err_clear,
    output logic             recalc_req,
    output logic             iter_mode,
    output logic             error
);
    scm_mode_e        mode, n_mode;
    logic [CNT_W-1:0] fail_cnt, n_cnt;
    logic [CNT_W:0]   cnt_inc, limit_eff;
    logic             pending, n_pend, n_req, n_err;

    // Next-state logic for mode, count, pending flag and outputs
    always_comb begin
        n_mode    = mode;
        n_cnt     = fail_cnt;
        n_pend    = pending;
        n_err     = error;
        n_req     = 1'b0;
        cnt_inc   = {1'b0, fail_cnt} + 1'b1;
        limit_eff = (fail_limit == '0) ? (CNT_W+1)'(1) : {1'b0, fail_limit};
        if (recalc_ack) begin
            n_pend = 1'b0;
        end
        if (err_clear) begin
            n_err  = 1'b0;
            n_mode = MODE_NORMAL;
            n_cnt  = '0;
        end else if (chk_valid) begin
            if (!fail) begin
                n_cnt = '0;
            end else begin
                if (!n_pend) begin
                    n_req  = 1'b1;
                    n_pend = 1'b1;
                end
                if (cnt_inc >= limit_eff) begin
                    n_cnt = '0;
                    if (mode == MODE_NORMAL) begin
                        n_mode = MODE_ITER;
                    end else begin
                        n_err = 1'b1;
                    end
                end else begin
                    n_cnt = cnt_inc[CNT_W-1:0];
                end
            end
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_NORMAL;
            fail_cnt   <= '0;
            pending    <= 1'b0;
            error      <= 1'b0;
            recalc_req <= 1'b0;
        end else begin
            mode       <= n_mode;
            fail_cnt   <= n_cnt;
            pending    <= n_pend;
            error      <= n_err;
            recalc_req <= n_req;
        end
    end

    assign iter_mode = (mode == MODE_ITER);

endmodule

// File: rtl/support_change_monitor.sv
// Top of the support change monitor: frame accumulation, energy test
// and escalation. A request appears two cycles after the last pair.
// Assumes synchronous active-low reset and a single clock.
module support_change_monitor
    import scm_pkg::*;
#(
    parameter int  DW        = 18,
    parameter int  FRAME_LEN = 12,
    parameter int  CNT_W     = 8,
    localparam int ACC_W     = acc_width(DW, FRAME_LEN),
    localparam int EW        = 2 * ACC_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] samp_re,
    input  logic signed [DW-1:0] samp_im,
    input  logic signed [DW-1:0] ctl_re,
    input  logic signed [DW-1:0] ctl_im,
    input  logic [EW-1:0]        threshold,
    input  logic [CNT_W-1:0]     fail_limit,
    input  logic                 recalc_ack,
    input  logic                 err_clear,
    output logic                 recalc_req,
    output logic                 iter_mode,
    output logic                 error
);
    logic                    frame_done;
    logic signed [ACC_W-1:0] sum_re, sum_im;
    logic                    chk_valid, fail;

    scm_cmac #(.DW(DW), .FRAME_LEN(FRAME_LEN), .ACC_W(ACC_W)) u_cmac (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .s_re(samp_re), .s_im(samp_im), .c_re(ctl_re), .c_im(ctl_im),
        .done(frame_done), .sum_re(sum_re), .sum_im(sum_im)
    );

    scm_energy #(.ACC_W(ACC_W), .EW(EW)) u_energy (
        .clk(clk), .rst_n(rst_n), .done(frame_done),
        .sum_re(sum_re), .sum_im(sum_im), .threshold(threshold),
        .chk_valid(chk_valid), .fail(fail)
    );

    scm_escalate #(.CNT_W(CNT_W)) u_esc (
        .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .fail(fail),
        .fail_limit(fail_limit), .recalc_ack(recalc_ack), .err_clear(err_clear),
        .recalc_req(recalc_req), .iter_mode(iter_mode), .error(error)
    );

endmodule

// File: rtl/scm_checker.sv
// Temporal checks on the support change monitor, bound to its top.
// Tracks request/acknowledge state from the ports only.
module scm_checker (
    input logic clk,
    input logic rst_n,
    input logic recalc_req,
    input logic recalc_ack,
    input logic iter_mode,
    input logic error,
    input logic err_clear,
    input logic chk_valid
);
    logic pend;

    // Outstanding-request flag seen from the ports
    always_ff @(posedge clk) begin
        if (!rst_n)          pend <= 1'b0;
        else if (recalc_ack) pend <= 1'b0;
        else if (recalc_req) pend <= 1'b1;
    end

    assert_req_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_req |=> !recalc_req);

    assert_req_after_verdict_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recalc_req |-> $past(chk_valid));

    assert_no_req_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !recalc_ack) |=> !recalc_req);

    assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !err_clear) |=> error);

    assert_error_in_iter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> iter_mode);

    assert_iter_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_mode && !err_clear) |=> iter_mode);

    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_clear |=> (!error && !iter_mode));

    assert_rise_on_verdict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iter_mode) |-> $past(chk_valid));

endmodule

bind support_change_monitor scm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .recalc_req(recalc_req), .recalc_ack(recalc_ack),
    .iter_mode(iter_mode), .error(error), .err_clear(err_clear), .chk_valid(chk_valid)
);

// File: tb/support_change_monitor_tb.sv
// Directed bench for the support change monitor; one task per scenario.
module support_change_monitor_tb;
    localparam int EW = 82;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               frame_start = 1'b0, in_valid = 1'b0;
    logic signed [17:0] samp_re = '0, samp_im = '0, ctl_re = '0, ctl_im = '0;
    logic [EW-1:0]      threshold = '0;
    logic [7:0]         fail_limit = 8'd100;
    logic               recalc_ack = 1'b0, err_clear = 1'b0;
    logic               recalc_req, iter_mode, error;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    support_change_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
        .samp_re(samp_re), .samp_im(samp_im), .ctl_re(ctl_re), .ctl_im(ctl_im),
        .threshold(threshold), .fail_limit(fail_limit), .recalc_ack(recalc_ack),
        .err_clear(err_clear), .recalc_req(recalc_req), .iter_mode(iter_mode),
        .error(error)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] exp_energy(input longint sr, input longint si,
                                                 input longint cr, input longint ci,
                                                 input longint n);
        logic signed [127:0] re, im, e;
        re = n * (sr * cr - si * ci);
        im = n * (sr * ci + si * cr);
        e  = re * re + im * im;
        return e[EW-1:0];
    endfunction

    task automatic pair(input int sr, input int si, input int cr, input int ci, input bit fs);
        @(negedge clk);
        samp_re = 18'(sr); samp_im = 18'(si); ctl_re = 18'(cr); ctl_im = 18'(ci);
        in_valid = 1'b1; frame_start = fs;
    endtask

    // Close a frame and check the request in its decision cycle
    task automatic finish(input bit exp_req, input string tag);
        @(negedge clk); in_valid = 1'b0; frame_start = 1'b0;
        @(negedge clk); chk(recalc_req == 1'b0, {tag, " early"}, recalc_req, 0);
        @(negedge clk); chk(recalc_req == exp_req, tag, recalc_req, exp_req);
        @(negedge clk); chk(recalc_req == 1'b0, {tag, " width"}, recalc_req, 0);
    endtask

    task automatic frame(input int sr, input int si, input int cr, input int ci,
                         input bit exp_req, input string tag);
        for (int i = 0; i < 12; i++) pair(sr, si, cr, ci, 1'b0);
        finish(exp_req, tag);
    endtask

    task automatic ack();
        @(negedge clk); recalc_ack = 1'b1;
        @(negedge clk); recalc_ack = 1'b0;
    endtask

    task automatic clear_err();
        @(negedge clk); err_clear = 1'b1;
        @(negedge clk); err_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk(recalc_req == 0, "R11 req", recalc_req, 0);
        chk(iter_mode == 0, "R11 iter", iter_mode, 0);
        chk(error == 0, "R11 error", error, 0);
    endtask

    task automatic t_boundary();
        threshold = exp_energy(1, 0, 1, 0, 12);
        chk(threshold == 144, "R2 model", threshold[31:0], 144);
        frame(1, 0, 1, 0, 1'b0, "R3 equal passes");
        threshold = 143;
        frame(1, 0, 1, 0, 1'b1, "R3 above fails R5");
        ack();
    endtask

    task automatic t_complex();
        threshold = exp_energy(0, 3, 0, 2, 12);
        frame(0, 3, 0, 2, 1'b0, "R1 imag*imag pass");
        threshold = threshold - 1;
        frame(0, 3, 0, 2, 1'b1, "R1 imag*imag fail");
        ack();
        threshold = exp_energy(3, 0, 0, 2, 12) - 1;
        frame(3, 0, 0, 2, 1'b1, "R1 cross term fail");
        ack();
        frame(-3, 0, 0, 2, 1'b1, "R1 negative cross fail");
        ack();
    endtask

    task automatic t_extreme();
        threshold = exp_energy(-131072, -131072, -131072, 131071, 12);
        frame(-131072, -131072, -131072, 131071, 1'b0, "R3 full scale equal");
        threshold = threshold - 1;
        frame(-131072, -131072, -131072, 131071, 1'b1, "R3 full scale above");
        ack();
    endtask

    task automatic t_count();
        threshold = 0;
        for (int i = 0; i < 11; i++) begin
            pair(5, 0, 5, 0, 1'b0);
            if (i == 4) begin @(negedge clk); in_valid = 1'b0; @(negedge clk); end
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(recalc_req == 0, "R2 eleven pairs no verdict", recalc_req, 0);
        pair(5, 0, 5, 0, 1'b0);
        finish(1'b1, "R2 twelfth pair decides");
        ack();
    endtask

    task automatic t_pending();
        threshold = 0;
        frame(1, 0, 1, 0, 1'b1, "R8 first request");
        frame(1, 0, 1, 0, 1'b0, "R8 held while pending");
        ack();
        frame(1, 0, 1, 0, 1'b1, "R8 request after ack");
        ack();
    endtask

    task automatic t_frame_start();
        threshold = 0;
        for (int i = 0; i < 5; i++) pair(100, 0, 100, 0, 1'b0);
        pair(0, 0, 0, 0, 1'b1);
        for (int i = 0; i < 11; i++) pair(0, 0, 0, 0, 1'b0);
        finish(1'b0, "R4 partial discarded");
        for (int i = 0; i < 3; i++) pair(0, 0, 0, 0, 1'b0);
        pair(7, 0, 7, 0, 1'b1);
        for (int i = 0; i < 11; i++) pair(0, 0, 0, 0, 1'b0);
        finish(1'b1, "R4 start pair counted");
        ack();
    endtask

    task automatic t_escalate();
        clear_err();
        fail_limit = 3;
        threshold = 0;
        frame(1, 0, 1, 0, 1'b1, "R6 fail 1"); ack();
        frame(1, 0, 1, 0, 1'b1, "R6 fail 2"); ack();
        frame(0, 0, 0, 0, 1'b0, "R7 pass");
        frame(1, 0, 1, 0, 1'b1, "R7 fail 1"); ack();
        frame(1, 0, 1, 0, 1'b1, "R7 fail 2"); ack();
        chk(iter_mode == 0, "R7 count cleared by pass", iter_mode, 0);
        frame(1, 0, 1, 0, 1'b1, "R6 fail 3"); ack();
        chk(iter_mode == 1, "R6 iteration mode", iter_mode, 1);
        frame(0, 0, 0, 0, 1'b0, "R7 pass in iter");
        chk(iter_mode == 1, "R7 mode kept", iter_mode, 1);
        frame(1, 0, 1, 0, 1'b1, "R9 fail 1"); ack();
        frame(1, 0, 1, 0, 1'b1, "R9 fail 2"); ack();
        chk(error == 0, "R9 not early", error, 0);
        frame(1, 0, 1, 0, 1'b1, "R9 fail 3"); ack();
        chk(error == 1, "R9 error set", error, 1);
        frame(0, 0, 0, 0, 1'b0, "R9 pass after error");
        chk(error == 1, "R9 error held", error, 1);
        clear_err();
        chk(error == 0, "R10 error cleared", error, 0);
        chk(iter_mode == 0, "R10 normal mode", iter_mode, 0);
    endtask

    task automatic t_limit_zero();
        fail_limit = 0;
        threshold = 0;
        frame(1, 0, 1, 0, 1'b1, "R6 limit zero fail");
        ack();
        chk(iter_mode == 1, "R6 limit zero escalates", iter_mode, 1);
        clear_err();
        fail_limit = 100;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boundary();
        t_complex();
        t_extreme();
        t_count();
        t_pending();
        t_frame_start();
        t_escalate();
        t_limit_zero();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule